// File: doc/BRIEF.md
# PWM operator action generator

This block turns one selected counting timebase into two independent pulse-width outputs, `pwm_a` and `pwm_b`. Each cycle it picks one of three external timebases through `timer_sel`, taking that timebase's count, direction, period and step strobe. The count is compared with zero, with the period, and with two compare values, one for each output. A step strobe marks a tick where the timebase advanced, and only on such a tick are these comparisons treated as events.

Each output owns a 20-bit action word. The word holds a 2-bit action code for every event (zero, period, compare A, compare B) in each count direction. The code either leaves the output alone, forces it low, forces it high or inverts it. Each output level is a two-state machine with states `LVL_LO` and `LVL_HI`. The transitions are *force-low* (to `LVL_LO`), *force-high* (to `LVL_HI`), *toggle* (to the other state) and *keep* (no move). The chosen action takes effect at the clock edge that ends the tick cycle.

Each compare value is written into a shadow register. An update-mode mask per output decides when the shadow value becomes the active compare value: at the write itself, at a counter-zero tick, at a period tick, or at either of the two. The active compare values are brought out so the loading can be observed.

Top module: `pwm_action_gen`

## Requirements
- R1: While reset is asserted and right after it, both outputs are low and both active compare values are 0.
- R2: Action codes are 2 bits: 0 keeps the level, 1 drives low, 2 drives high, 3 inverts. The new level appears at the clock edge that ends the tick cycle.
- R3: The action word fields sit at these bit offsets. For up-counting: zero [1:0], period [3:2], compare A [5:4], compare B [7:6]. For down-counting: zero [13:12], period [15:14], compare A [17:16], compare B [19:18]. `tb_down`=1 selects the down-counting fields.
- R4: Events are detected only on a cycle where the selected timebase's step bit is 1. With step 0, the outputs hold whatever the count is.
- R5: `timer_sel` values 0, 1 and 2 select timebase 0, 1 and 2. The value 3 selects timebase 2.
- R6: When several events coincide, the one event with a non-zero code and the highest priority decides the level. The priority order is compare B, then compare A, then period, then zero.
- R7: With update mode 0, a compare write becomes the active value at the write's clock edge.
- R8: With mode bit 0 set, a pending shadow value loads on a step tick whose count is zero. Without a step tick or a write, the active value never changes.
- R9: With mode bit 1 set, a pending shadow value loads on a step tick whose count equals the period. With both bits set, either boundary loads it.
- R10: For an up-counting timebase with period 99 and compare A 50, an action word with high at up-zero and low at up-compare-A keeps `pwm_a` high for exactly 50 of every 100 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | 48 | Counts of the three timebases, timebase i in bits [16i+15:16i] |
| tb_down | input | 3 | Count direction per timebase, 1 = down |
| tb_step | input | 3 | Per-timebase strobe, 1 = counter advanced this cycle |
| tb_period | input | 48 | Period values of the three timebases |
| timer_sel | input | 2 | Timebase select, 3 aliases 2 |
| cmpa_wr | input | 1 | Write strobe for compare A shadow |
| cmpa_val | input | 16 | Compare A write data |
| cmpa_mode | input | 2 | Compare A update mask: bit0 zero, bit1 period, 0 immediate |
| cmpb_wr | input | 1 | Write strobe for compare B shadow |
| cmpb_val | input | 16 | Compare B write data |
| cmpb_mode | input | 2 | Compare B update mask |
| act_word_a | input | 20 | Action word for output A |
| act_word_b | input | 20 | Action word for output B |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |
| cmpa_cur | output | 16 | Active compare A value |
| cmpb_cur | output | 16 | Active compare B value |

## Verification
Two groups of functions can land in the same cycle. The first is events on one output: a period and a compare can coincide, and so can a zero and a compare. The second is a shadow load and the comparison that uses the active compare value. The bench sets a compare value equal to the period, or equal to zero, and steps the count onto that value. The actions are chosen so that each competing event would drive the opposite level, so the observed output shows which event won. A load is judged by reading the active compare value after a boundary tick, then checking that the next event uses the new value.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;

    localparam int ACT_W      = 20;
    localparam int OFS_ZERO   = 0;
    localparam int OFS_PERIOD = 2;
    localparam int OFS_CMPA   = 4;
    localparam int OFS_CMPB   = 6;
    localparam int OFS_DOWN   = 12;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    typedef struct packed {
        logic zero;
        logic period;
        logic cmp_a;
        logic cmp_b;
    } evt_t;

endpackage

// File: rtl/pwm_tb_select.sv
module pwm_tb_select #(
    parameter int CW  = 16,
    parameter int NTB = 3,
    parameter int SW  = 2
) (
    input  logic [NTB*CW-1:0] cnt_all,
    input  logic [NTB*CW-1:0] per_all,
    input  logic [NTB-1:0]    dir_all,
    input  logic [NTB-1:0]    step_all,
    input  logic [SW-1:0]     sel,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     per,
    output logic              dir,
    output logic              step
);
    int idx;

    // Select values beyond the last timebase fold onto the last one
    always_comb begin
        idx  = (int'(sel) >= NTB) ? NTB - 1 : int'(sel);
        cnt  = cnt_all[idx*CW +: CW];
        per  = per_all[idx*CW +: CW];
        dir  = dir_all[idx];
        step = step_all[idx];
    end

endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wr_val,
    input  logic [1:0]    mode,
    input  logic          step,
    input  logic          at_zero,
    input  logic          at_period,
    output logic [CW-1:0] active
);
    logic [CW-1:0] shadow_q;
    logic          pend_q;
    logic          load_now;

    assign load_now = pend_q && step &&
                      ((mode[0] && at_zero) || (mode[1] && at_period));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active   <= '0;
            pend_q   <= 1'b0;
        end else if (wr) begin
            shadow_q <= wr_val;
            if (mode == 2'b00) begin
                active <= wr_val;
                pend_q <= 1'b0;
            end else begin
                pend_q <= 1'b1;
            end
        end else if (load_now) begin
            active <= shadow_q;
            pend_q <= 1'b0;
        end
    end

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && mode == 2'b00) |=> (active == $past(wr_val))); // R7

    AST_NO_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !step) |=> $stable(active)); // R8

    AST_NO_LOAD_MIDCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !at_zero && !at_period) |=> $stable(active)); // R9

endmodule

// File: rtl/pwm_out_gen.sv
module pwm_out_gen
    import pwm_act_pkg::*;
#(
    parameter int AW = ACT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          down,
    input  evt_t          evt,
    input  logic [AW-1:0] act,
    output logic          level
);
    int   base;
    act_e f_zero, f_per, f_cmpa, f_cmpb;
    act_e code;
    lvl_e lvl_q, lvl_d;
    logic unused_gap;

    assign unused_gap = ^act[OFS_DOWN-1:OFS_CMPB+2];

    // Field pick by direction, then priority: later assignments win
    always_comb begin
        base   = down ? OFS_DOWN : 0;
        f_zero = act_e'(act[base + OFS_ZERO   +: 2]);
        f_per  = act_e'(act[base + OFS_PERIOD +: 2]);
        f_cmpa = act_e'(act[base + OFS_CMPA   +: 2]);
        f_cmpb = act_e'(act[base + OFS_CMPB   +: 2]);
        code   = ACT_KEEP;
        if (step) begin
            if (evt.zero   && f_zero != ACT_KEEP) code = f_zero;
            if (evt.period && f_per  != ACT_KEEP) code = f_per;
            if (evt.cmp_a  && f_cmpa != ACT_KEEP) code = f_cmpa;
            if (evt.cmp_b  && f_cmpb != ACT_KEEP) code = f_cmpb;
        end
    end

    always_comb begin
        unique case (code)
            ACT_KEEP:   lvl_d = lvl_q;
            ACT_LOW:    lvl_d = LVL_LO;
            ACT_HIGH:   lvl_d = LVL_HI;
            ACT_TOGGLE: lvl_d = (lvl_q == LVL_HI) ? LVL_LO : LVL_HI;
            default:    lvl_d = lvl_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= LVL_LO;
        else        lvl_q <= lvl_d;
    end

    always_comb level = (lvl_q == LVL_HI);

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(level)); // R4

    AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (code == ACT_HIGH) |=> level); // R2

    AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (code == ACT_LOW) |=> !level); // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (code == ACT_TOGGLE) |=> (level != $past(level))); // R2

endmodule

// File: rtl/pwm_action_gen.sv
module pwm_action_gen
    import pwm_act_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NTB = 3,
    parameter int SW  = 2,
    parameter int AW  = ACT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NTB*CW-1:0] tb_count,
    input  logic [NTB-1:0]    tb_down,
    input  logic [NTB-1:0]    tb_step,
    input  logic [NTB*CW-1:0] tb_period,
    input  logic [SW-1:0]     timer_sel,
    input  logic              cmpa_wr,
    input  logic [CW-1:0]     cmpa_val,
    input  logic [1:0]        cmpa_mode,
    input  logic              cmpb_wr,
    input  logic [CW-1:0]     cmpb_val,
    input  logic [1:0]        cmpb_mode,
    input  logic [AW-1:0]     act_word_a,
    input  logic [AW-1:0]     act_word_b,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic [CW-1:0]     cmpa_cur,
    output logic [CW-1:0]     cmpb_cur
);
    localparam int NOUT = 2;

    logic [CW-1:0] sel_cnt, sel_per;
    logic          sel_dir, sel_step;
    evt_t          evt;

    logic [CW-1:0] wr_val  [NOUT];
    logic          wr_stb  [NOUT];
    logic [1:0]    wr_mode [NOUT];
    logic [AW-1:0] act_w   [NOUT];
    logic [CW-1:0] cmp_cur [NOUT];
    logic          lvl     [NOUT];

    pwm_tb_select #(.CW(CW), .NTB(NTB), .SW(SW)) u_sel (
        .cnt_all  (tb_count),
        .per_all  (tb_period),
        .dir_all  (tb_down),
        .step_all (tb_step),
        .sel      (timer_sel),
        .cnt      (sel_cnt),
        .per      (sel_per),
        .dir      (sel_dir),
        .step     (sel_step)
    );

    assign wr_val[0]  = cmpa_val;
    assign wr_val[1]  = cmpb_val;
    assign wr_stb[0]  = cmpa_wr;
    assign wr_stb[1]  = cmpb_wr;
    assign wr_mode[0] = cmpa_mode;
    assign wr_mode[1] = cmpb_mode;
    assign act_w[0]   = act_word_a;
    assign act_w[1]   = act_word_b;

    always_comb begin
        evt.zero   = (sel_cnt == '0);
        evt.period = (sel_cnt == sel_per);
        evt.cmp_a  = (sel_cnt == cmp_cur[0]);
        evt.cmp_b  = (sel_cnt == cmp_cur[1]);
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        pwm_cmp_shadow #(.CW(CW)) u_shadow (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr        (wr_stb[g]),
            .wr_val    (wr_val[g]),
            .mode      (wr_mode[g]),
            .step      (sel_step),
            .at_zero   (evt.zero),
            .at_period (evt.period),
            .active    (cmp_cur[g])
        );

        pwm_out_gen #(.AW(AW)) u_gen (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (sel_step),
            .down  (sel_dir),
            .evt   (evt),
            .act   (act_w[g]),
            .level (lvl[g])
        );
    end

    assign pwm_a    = lvl[0];
    assign pwm_b    = lvl[1];
    assign cmpa_cur = cmp_cur[0];
    assign cmpb_cur = cmp_cur[1];

endmodule

// File: tb/pwm_action_gen_tb.sv
`timescale 1ns/1ps
module pwm_action_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] tb_count;
    logic [2:0]  tb_down, tb_step;
    logic [47:0] tb_period;
    logic [1:0]  timer_sel;
    logic        cmpa_wr, cmpb_wr;
    logic [15:0] cmpa_val, cmpb_val;
    logic [1:0]  cmpa_mode, cmpb_mode;
    logic [19:0] act_word_a, act_word_b;
    logic        pwm_a, pwm_b;
    logic [15:0] cmpa_cur, cmpb_cur;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    pwm_action_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_down(tb_down),
        .tb_step(tb_step), .tb_period(tb_period), .timer_sel(timer_sel),
        .cmpa_wr(cmpa_wr), .cmpa_val(cmpa_val), .cmpa_mode(cmpa_mode),
        .cmpb_wr(cmpb_wr), .cmpb_val(cmpb_val), .cmpb_mode(cmpb_mode),
        .act_word_a(act_word_a), .act_word_b(act_word_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .cmpa_cur(cmpa_cur), .cmpb_cur(cmpb_cur)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [15:0] cnt;
        logic        dn;
        logic        stp;
        logic        exp_a;
        logic        exp_b;
    } vec_t;

    // act_a = 0x00012, act_b = 0x8004C, cmp A = 4, cmp B = 7, periods 9
    localparam vec_t VEC [13] = '{
        '{2'd0, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 up zero high on A
        '{2'd0, 16'd3, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 no event
        '{2'd0, 16'd4, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 up cmpA low
        '{2'd0, 16'd7, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 up cmpB low on B
        '{2'd0, 16'd9, 1'b0, 1'b1, 1'b0, 1'b1},  // R2 period toggle on B
        '{2'd0, 16'd9, 1'b0, 1'b0, 1'b0, 1'b1},  // R4 frozen, no repeat
        '{2'd0, 16'd9, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 toggle back
        '{2'd0, 16'd0, 1'b0, 1'b1, 1'b1, 1'b0},  // R3 zero again
        '{2'd0, 16'd7, 1'b1, 1'b1, 1'b1, 1'b1},  // R3 down cmpB high
        '{2'd1, 16'd4, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 timebase 1
        '{2'd3, 16'd0, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 select 3 aliases 2
        '{2'd2, 16'd4, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 timebase 2
        '{2'd2, 16'd7, 1'b0, 1'b1, 1'b0, 1'b0}   // R5 cmpB via timebase 2
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [1:0] sel, input logic [15:0] cnt,
                        input logic dn, input logic stp);
        int idx = (sel == 2'd3) ? 2 : int'(sel);
        timer_sel = sel;
        for (int i = 0; i < 3; i++) begin
            if (i == idx) begin
                tb_count[i*16 +: 16] = cnt;
                tb_down[i] = dn;
                tb_step[i] = stp;
            end else begin
                tb_count[i*16 +: 16] = 16'd4;
                tb_down[i] = 1'b0;
                tb_step[i] = 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic wr_a(input logic [15:0] v, input logic [1:0] m);
        tb_step = 3'b000;
        cmpa_mode = m; cmpa_val = v; cmpa_wr = 1'b1;
        @(negedge clk);
        cmpa_wr = 1'b0;
    endtask

    task automatic wr_b(input logic [15:0] v, input logic [1:0] m);
        tb_step = 3'b000;
        cmpb_mode = m; cmpb_val = v; cmpb_wr = 1'b1;
        @(negedge clk);
        cmpb_wr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int high_cnt;
        rst_n = 1'b0;
        tb_count = '0; tb_down = '0; tb_step = '0;
        tb_period = {16'd9, 16'd9, 16'd9};
        timer_sel = 2'd0;
        cmpa_wr = 0; cmpb_wr = 0; cmpa_val = 0; cmpb_val = 0;
        cmpa_mode = 0; cmpb_mode = 0;
        act_word_a = 20'h00012; act_word_b = 20'h8004C;
        repeat (3) @(negedge clk);
        chk("R1 pwm_a in reset", int'(pwm_a), 0);
        chk("R1 pwm_b in reset", int'(pwm_b), 0);
        chk("R1 cmpa_cur in reset", int'(cmpa_cur), 0);
        chk("R1 cmpb_cur in reset", int'(cmpb_cur), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pwm_a after reset", int'(pwm_a), 0);
        chk("R1 pwm_b after reset", int'(pwm_b), 0);

        wr_a(16'd4, 2'b00);
        chk("R7 immediate load A", int'(cmpa_cur), 4);
        wr_b(16'd7, 2'b00);
        chk("R7 immediate load B", int'(cmpb_cur), 7);

        for (int v = 0; v < 13; v++) begin
            tick(VEC[v].sel, VEC[v].cnt, VEC[v].dn, VEC[v].stp);
            chk($sformatf("R2/R3/R4/R5 vec%0d pwm_a", v), int'(pwm_a), int'(VEC[v].exp_a));
            chk($sformatf("R2/R3/R4/R5 vec%0d pwm_b", v), int'(pwm_b), int'(VEC[v].exp_b));
        end

        // R6 priority: compare A over period
        act_word_a = 20'h00024;
        wr_a(16'd9, 2'b00);
        tick(2'd0, 16'd9, 1'b0, 1'b1);
        chk("R6 cmpA beats period", int'(pwm_a), 1);
        // R6 compare B over compare A
        wr_b(16'd9, 2'b00);
        act_word_a = 20'h00064;
        tick(2'd0, 16'd9, 1'b0, 1'b1);
        chk("R6 cmpB beats cmpA", int'(pwm_a), 0);
        chk("R6 cmpB beats period on B", int'(pwm_b), 0);
        // R6 period over zero (period 0)
        tb_period[15:0] = 16'd0;
        act_word_a = 20'h00009;
        tick(2'd0, 16'd0, 1'b0, 1'b1);
        chk("R6 period beats zero", int'(pwm_a), 1);
        tb_period[15:0] = 16'd9;
        // R6 zero-code compare does not mask zero action
        act_word_a = 20'h00001;
        wr_a(16'd0, 2'b00);
        tick(2'd0, 16'd0, 1'b0, 1'b1);
        chk("R6 code 0 event skipped", int'(pwm_a), 0);

        // R3 down-count fields
        act_word_a = 20'h36000;
        wr_a(16'd5, 2'b00);
        tick(2'd0, 16'd0, 1'b1, 1'b1);
        chk("R3 down zero high", int'(pwm_a), 1);
        tick(2'd0, 16'd9, 1'b1, 1'b1);
        chk("R3 down period low", int'(pwm_a), 0);
        tick(2'd0, 16'd5, 1'b1, 1'b1);
        chk("R3 down cmpA toggle", int'(pwm_a), 1);
        tick(2'd0, 16'd5, 1'b0, 1'b1);
        chk("R3 up cmpA field empty", int'(pwm_a), 1);

        // Shadow loading
        wr_a(16'd6, 2'b01);
        chk("R8 write held in shadow", int'(cmpa_cur), 5);
        tick(2'd0, 16'd5, 1'b0, 1'b1);
        chk("R8 no load mid count", int'(cmpa_cur), 5);
        tick(2'd0, 16'd0, 1'b0, 1'b1);
        chk("R8 load at zero", int'(cmpa_cur), 6);
        wr_a(16'd2, 2'b10);
        tick(2'd0, 16'd0, 1'b0, 1'b1);
        chk("R9 no load at zero", int'(cmpa_cur), 6);
        tick(2'd0, 16'd9, 1'b0, 1'b1);
        chk("R9 load at period", int'(cmpa_cur), 2);
        wr_a(16'd8, 2'b11);
        tick(2'd0, 16'd9, 1'b0, 1'b1);
        chk("R9 both bits, period loads", int'(cmpa_cur), 8);
        wr_a(16'd3, 2'b01);
        tick(2'd0, 16'd0, 1'b0, 1'b0);
        chk("R8 frozen zero no load", int'(cmpa_cur), 8);
        tick(2'd0, 16'd0, 1'b0, 1'b1);
        chk("R8 stepped zero loads", int'(cmpa_cur), 3);

        // R10 duty
        tb_period[15:0] = 16'd99;
        act_word_a = 20'h00012;
        wr_a(16'd50, 2'b00);
        high_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            tick(2'd0, 16'(i % 100), 1'b0, 1'b1);
            if (pwm_a) high_cnt++;
        end
        chk("R10 high ticks over two periods", high_cnt, 100);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule